// File: doc/BRIEF.md
# Chip-Select Timed Power Mode Controller

This block decides whether a serial sampling converter is powered up, waking, or powered down. There is no control register. The decision comes from one thing: how many serial-clock falling edges have occurred in the frame when the active-low chip select is released. Chip select and the serial clock are asynchronous to the block. Each is brought into a free-running system clock domain, and their edges are detected there.

A frame that releases chip select very early is treated as a glitch, and the mode does not change. A release in a middle window powers the converter down. A release late in the frame aborts the conversion but leaves the converter powered. A full frame produces a result-valid strobe.

From power-down, a falling chip select begins a wake-up. The wake-up completes only when both of these hold:
- chip select stayed low through the wake threshold edge;
- a power-up timer, counted in system clocks, has run out.

The frame that wakes the converter is a dummy, and its data is never flagged valid.

Top module: `cs_pwr_mode_ctl`

## Requirements
- R1: After reset the mode output is normal (2'b10) with ready high when RESET_DOWN is 0, or power-down (2'b00) with ready low when RESET_DOWN is 1. Mode encoding: 2'b00 power-down, 2'b01 waking, 2'b10 normal.
- R2: In normal mode, chip select rising after fewer than DOWN_EDGE (2) serial-clock falling edges leaves the mode at normal and produces no result strobe.
- R3: In normal mode, chip select rising after at least DOWN_EDGE and fewer than WAKE_EDGE (10) falling edges moves the mode to power-down and drops ready.
- R4: In normal mode, chip select rising after at least WAKE_EDGE and fewer than FRAME_EDGES (16) falling edges keeps the mode at normal and produces no result strobe.
- R5: A frame that starts in normal mode and reaches FRAME_EDGES falling edges raises resultValid for exactly one system clock.
- R6: In power-down, the mode stays at power-down until a chip-select falling edge, which moves it to waking (ready low).
- R7: While waking, chip select rising before WAKE_EDGE falling edges returns the mode to power-down.
- R8: While waking, once WAKE_EDGE falling edges have occurred and the power-up timer has expired, the mode becomes normal. The waking frame never raises resultValid.
- R9: The power-up timer runs PWRUP_CYCLES system clocks from the detected chip-select fall. If the wake threshold is met earlier, the mode stays at waking until the timer expires.
- R10: The falling-edge count saturates at FRAME_EDGES. A frame longer than FRAME_EDGES edges raises resultValid only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock; also times power-up |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low chip select, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous, idles high |
| pwrMode | output | 2 | 00 power-down, 01 waking, 10 normal |
| ready | output | 1 | High in normal mode |
| resultValid | output | 1 | One-clock strobe on a completed non-dummy frame |

## Verification
The bench drives chip-select releases on both sides of each threshold: one edge against two, nine against ten, and fifteen against sixteen. A design with an off-by-one compare would power down on a glitch, or stay up when it should sleep. A wake frame that meets the edge threshold before the timer runs out is sampled while still waking; a design that skipped the timer would report ready too early. Dummy wake frames and over-long frames are checked for zero and one result strobe. A design that flagged the dummy conversion, or failed to saturate its edge count, would produce extra strobes.

// File: rtl/cs_pwr_mode_pkg.sv
package cs_pwr_mode_pkg;

  typedef enum logic [1:0] {
    MODE_DOWN = 2'b00,
    MODE_WAKE = 2'b01,
    MODE_NORM = 2'b10
  } pwrMode_e;

  // Events reported by the datapath to the control
  typedef struct packed {
    logic csFall;
    logic csRise;
    logic sclkFall;
    logic csLow;
    logic timerDone;
  } dpEvents_t;

  // Strobes issued by the control to the datapath
  typedef struct packed {
    logic timerStart;
  } ctlStrobe_t;

endpackage

// File: rtl/cs_pin_sync.sv
module cs_pin_sync #(
  parameter int WIDTH = 2,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] IDLE = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] levelPrev
);

  logic [WIDTH-1:0] chain [STAGES+1];

  assign chain[0] = pinIn;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stageQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stageQ <= IDLE;
      else       stageQ <= chain[s];
    end
    assign chain[s+1] = stageQ;
  end

  assign level = chain[STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) levelPrev <= IDLE;
    else       levelPrev <= level;
  end

endmodule

// File: rtl/cs_frame_datapath.sv
module cs_frame_datapath
  import cs_pwr_mode_pkg::*;
#(
  parameter int FRAME_EDGES = 16,
  parameter int PWRUP_CYCLES = 100,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W = $clog2(FRAME_EDGES + 1),
  localparam int TMR_W = (PWRUP_CYCLES < 2) ? 1 : $clog2(PWRUP_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             sclk,
  input  ctlStrobe_t       ctl,
  output dpEvents_t        ev,
  output logic [CNT_W-1:0] edgeCnt
);

  logic [1:0] pinLevel, pinPrev;
  logic [TMR_W-1:0] tmrQ;

  cs_pin_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .IDLE(2'b11)) sync_i (
    .clk      (clk),
    .rstN     (rstN),
    .pinIn    ({sclk, csN}),
    .level    (pinLevel),
    .levelPrev(pinPrev)
  );

  assign ev.csFall    = pinPrev[0] & ~pinLevel[0];
  assign ev.csRise    = ~pinPrev[0] & pinLevel[0];
  assign ev.sclkFall  = pinPrev[1] & ~pinLevel[1];
  assign ev.csLow     = ~pinLevel[0];
  assign ev.timerDone = (tmrQ == '0);

  // Serial-clock falling edges within the current frame, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edgeCnt <= '0;
    end else if (ev.csFall) begin
      edgeCnt <= '0;
    end else if (ev.sclkFall && ev.csLow && edgeCnt < CNT_W'(FRAME_EDGES)) begin
      edgeCnt <= edgeCnt + 1'b1;
    end
  end

  // Power-up delay timer in system clocks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmrQ <= '0;
    end else if (ctl.timerStart) begin
      tmrQ <= TMR_W'(PWRUP_CYCLES);
    end else if (tmrQ != '0) begin
      tmrQ <= tmrQ - 1'b1;
    end
  end

  a_r10_cnt_bounded: assert property (@(posedge clk) disable iff (!rstN)
    edgeCnt <= CNT_W'(FRAME_EDGES));

  a_r10_cnt_clears: assert property (@(posedge clk) disable iff (!rstN)
    ev.csFall |=> (edgeCnt == '0));

  a_r9_timer_armed: assert property (@(posedge clk) disable iff (!rstN)
    ctl.timerStart |=> !ev.timerDone);

endmodule

// File: rtl/cs_mode_ctrl.sv
module cs_mode_ctrl
  import cs_pwr_mode_pkg::*;
#(
  parameter int FRAME_EDGES = 16,
  parameter int DOWN_EDGE = 2,
  parameter int WAKE_EDGE = 10,
  parameter bit RESET_DOWN = 1'b0,
  localparam int CNT_W = $clog2(FRAME_EDGES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpEvents_t        ev,
  input  logic [CNT_W-1:0] edgeCnt,
  output ctlStrobe_t       ctl,
  output pwrMode_e         modeQ,
  output logic             resultValid
);

  localparam pwrMode_e RESET_MODE = RESET_DOWN ? MODE_DOWN : MODE_NORM;

  logic frameLive;
  logic wakeMet;
  logic downWindow;
  logic lastEdge;
  logic wakeEdge;

  assign downWindow = (edgeCnt >= CNT_W'(DOWN_EDGE)) && (edgeCnt < CNT_W'(WAKE_EDGE));
  assign lastEdge   = ev.sclkFall && ev.csLow && (edgeCnt == CNT_W'(FRAME_EDGES - 1));
  assign wakeEdge   = ev.sclkFall && ev.csLow && (edgeCnt == CNT_W'(WAKE_EDGE - 1));

  assign ctl.timerStart = (modeQ == MODE_DOWN) && ev.csFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ       <= RESET_MODE;
      frameLive   <= 1'b0;
      wakeMet     <= 1'b0;
      resultValid <= 1'b0;
    end else begin
      resultValid <= 1'b0;
      unique case (modeQ)
        MODE_NORM: begin
          if (ev.csFall) begin
            frameLive <= 1'b1;
          end else if (ev.csRise) begin
            frameLive <= 1'b0;
            if (downWindow) modeQ <= MODE_DOWN;
          end
          resultValid <= frameLive && lastEdge;
        end
        MODE_DOWN: begin
          frameLive <= 1'b0;
          if (ev.csFall) begin
            modeQ   <= MODE_WAKE;
            wakeMet <= 1'b0;
          end
        end
        MODE_WAKE: begin
          frameLive <= 1'b0;
          if (ev.csRise && !wakeMet) begin
            modeQ <= MODE_DOWN;
          end else if (wakeMet && ev.timerDone) begin
            modeQ   <= MODE_NORM;
            wakeMet <= 1'b0;
          end else if (wakeEdge) begin
            wakeMet <= 1'b1;
          end
        end
        default: modeQ <= RESET_MODE;
      endcase
    end
  end

  a_r3_norm_leaves_on_release: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_NORM && !ev.csRise) |=> (modeQ == MODE_NORM));

  a_r6_down_holds: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_DOWN && !ev.csFall) |=> (modeQ == MODE_DOWN));

  a_r9_wake_waits_timer: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_WAKE) |=> (modeQ != MODE_NORM || $past(ev.timerDone)));

  a_r5_valid_only_normal: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> (modeQ == MODE_NORM));

  a_r5_valid_single: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

endmodule

// File: rtl/cs_pwr_mode_ctl.sv
module cs_pwr_mode_ctl
  import cs_pwr_mode_pkg::*;
#(
  parameter int FRAME_EDGES = 16,
  parameter int DOWN_EDGE = 2,
  parameter int WAKE_EDGE = 10,
  parameter int PWRUP_CYCLES = 100,
  parameter int SYNC_STAGES = 2,
  parameter bit RESET_DOWN = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sclk,
  output logic [1:0] pwrMode,
  output logic       ready,
  output logic       resultValid
);

  localparam int CNT_W = $clog2(FRAME_EDGES + 1);

  dpEvents_t        ev;
  ctlStrobe_t       ctl;
  logic [CNT_W-1:0] edgeCnt;
  pwrMode_e         modeQ;

  cs_frame_datapath #(
    .FRAME_EDGES (FRAME_EDGES),
    .PWRUP_CYCLES(PWRUP_CYCLES),
    .SYNC_STAGES (SYNC_STAGES)
  ) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .csN    (csN),
    .sclk   (sclk),
    .ctl    (ctl),
    .ev     (ev),
    .edgeCnt(edgeCnt)
  );

  cs_mode_ctrl #(
    .FRAME_EDGES(FRAME_EDGES),
    .DOWN_EDGE  (DOWN_EDGE),
    .WAKE_EDGE  (WAKE_EDGE),
    .RESET_DOWN (RESET_DOWN)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .ev         (ev),
    .edgeCnt    (edgeCnt),
    .ctl        (ctl),
    .modeQ      (modeQ),
    .resultValid(resultValid)
  );

  assign pwrMode = modeQ;
  assign ready   = (modeQ == MODE_NORM);

endmodule

// File: tb/cs_pwr_mode_ctl_tb_top.sv
module cs_pwr_mode_ctl_tb_top;

  localparam logic [1:0] M_DOWN = 2'b00;
  localparam logic [1:0] M_WAKE = 2'b01;
  localparam logic [1:0] M_NORM = 2'b10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sclk = 1'b1;
  logic [1:0] pwrMode;
  logic ready;
  logic resultValid;

  int checks = 0;
  int fails = 0;
  int pulseCnt = 0;
  bit finished = 1'b0;

  typedef struct {
    int pulses;
    logic [1:0] mode;
    string req;
  } expItem_t;

  expItem_t expQ[$];
  int pulseBase;

  always #5 clk = ~clk;

  cs_pwr_mode_ctl dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .csN        (csN),
    .sclk       (sclk),
    .pwrMode    (pwrMode),
    .ready      (ready),
    .resultValid(resultValid)
  );

  // monitor: counts result strobes
  always @(negedge clk) if (rstN && resultValid) pulseCnt++;

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic edges(int n);
    for (int i = 0; i < n; i++) begin
      sclk = 1'b0; waitClk(4);
      sclk = 1'b1; waitClk(4);
    end
  endtask

  // driver: runs a frame and pushes the expected outcome
  task automatic frame(int n, int expPulses, logic [1:0] expMode, string req);
    expItem_t it;
    pulseBase = pulseCnt;
    csN = 1'b0; waitClk(6);
    edges(n);
    csN = 1'b1; waitClk(8);
    it.pulses = expPulses; it.mode = expMode; it.req = req;
    expQ.push_back(it);
  endtask

  // scoreboard compare: pops the oldest expectation
  task automatic score();
    expItem_t it;
    it = expQ.pop_front();
    check({it.req, " mode"}, int'(pwrMode), int'(it.mode));
    check({it.req, " pulses"}, pulseCnt - pulseBase, it.pulses);
    check({it.req, " ready"}, int'(ready), int'(it.mode == M_NORM));
  endtask

  initial begin
    waitClk(3);
    rstN = 1'b1;
    waitClk(4);
    // R1 reset state with default parameters
    check("R1 mode", int'(pwrMode), int'(M_NORM));
    check("R1 ready", int'(ready), 1);
    check("R1 valid", int'(resultValid), 0);

    frame(0, 0, M_NORM, "R2 zero edges");  score();
    frame(1, 0, M_NORM, "R2 one edge");    score();
    frame(16, 1, M_NORM, "R5 full frame"); score();
    frame(10, 0, M_NORM, "R4 ten edges");  score();
    frame(15, 0, M_NORM, "R4 fifteen");    score();
    frame(9, 0, M_DOWN, "R3 nine edges");  score();

    // R6 waking on chip-select fall, then R7 early release
    pulseBase = pulseCnt;
    waitClk(20);
    check("R6 still down", int'(pwrMode), int'(M_DOWN));
    csN = 1'b0; waitClk(10);
    check("R6 waking mode", int'(pwrMode), int'(M_WAKE));
    check("R6 ready low", int'(ready), 0);
    edges(5);
    csN = 1'b1; waitClk(8);
    begin
      expItem_t it;
      it.pulses = 0; it.mode = M_DOWN; it.req = "R7 early release";
      expQ.push_back(it);
    end
    score();
    frame(9, 0, M_DOWN, "R7 nine edges");  score();

    // R9: wake threshold met before timer expires
    frame(10, 0, M_WAKE, "R9 timer pending"); score();
    waitClk(30);
    check("R8 woke after timer", int'(pwrMode), int'(M_NORM));
    check("R8 no dummy strobe", pulseCnt - pulseBase, 0);

    frame(2, 0, M_DOWN, "R3 two edges");     score();
    frame(20, 0, M_NORM, "R8 dummy frame");  score();
    frame(16, 1, M_NORM, "R5 after wake");   score();
    frame(20, 1, M_NORM, "R10 long frame");  score();

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule